// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches the bit stream that a line decoder produces and raises an alarm flag when the stream is close to all ones. It counts the zero bits inside measurement windows. An external window strobe marks where each window ends. Each bit arrives with a qualifier, so the block works at whatever bit rate the decoder clock carries. Bits whose qualifier is low are not sampled at all.

The alarm uses hysteresis across windows. It is raised only after a fixed number of back-to-back sparse windows; by default this is two windows, each holding fewer than three zeros. One dense window is enough to drop it. A window ends on the qualified bit in which the strobe is seen to fall. That bit still belongs to the window that is closing, and the next window starts with the following qualified bit. The alarm can change only on the clock edge that closes a window.

The logic that generates the strobe timing is outside this block.

Top module: `blue_alarm_det`

## Requirements
- R1: While `rst_n` is low, `alarm_o` is 0, the zero count is 0, the sparse-window history is empty and the stored strobe level is 0. A reset given while the alarm is high clears it.
- R2: Inputs are sampled only on rising clock edges where `bit_valid` is 1. While `bit_valid` is 0, `bit_data` and `win_strobe` have no effect on the zero count, the window boundaries or `alarm_o`.
- R3: A window boundary is a qualified bit in which `win_strobe` is 0 and the strobe level stored from the previous qualified bit is 1. Because the stored level resets to 0, a strobe that is held low after reset produces no boundary.
- R4: A qualified bit with `bit_data` = 0 that lands on a boundary counts toward the window that is closing. The following window starts counting from zero.
- R5: The zero count saturates at the threshold (3). A window with 3 or more zeros, however many, is dense.
- R6: At the boundary that closes the second consecutive sparse window (fewer than 3 zeros), `alarm_o` becomes 1 from the clock edge that samples that boundary bit. Further sparse windows keep it at 1.
- R7: At the boundary that closes a dense window, `alarm_o` becomes 0 from that clock edge, and the sparse-window history is emptied.
- R8: `alarm_o` changes only on a clock edge that samples a boundary bit.
- R9: The stretch from reset release to the first boundary counts as a window in its own right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| bit_valid | input | 1 | High on cycles that carry a decoded bit |
| bit_data | input | 1 | Decoded bit value; a 0 is counted |
| win_strobe | input | 1 | Window strobe; a falling edge between qualified bits closes a window |
| alarm_o | output | 1 | All-ones alarm flag |

## Verification
The bench builds the block with its default parameters: a zero threshold of 3 and two sparse windows to set the alarm. With these values, windows holding 0, 1, 2 and 3 zeros fall on both sides of the threshold. A window holding 20 zeros would wrap a count that was not clamped. A zero placed on a boundary bit moves a window from sparse to dense, so it shows which window the bit is assigned to. The defaults also let the bench show the full hysteresis path: a single sparse window leaves the alarm low, a second one raises it, and a dense window between two sparse ones resets the history.

// File: rtl/blue_alarm_pkg.sv
package blue_alarm_pkg;

  // Adds b to a and clamps the result at lim.
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // A window is sparse when its zero total is below the threshold.
  function automatic logic is_sparse(input int unsigned zeros,
                                     input int unsigned thresh);
    return zeros < thresh;
  endfunction

  // Returns 1 once the run of sparse windows reaches the count that sets the alarm.
  function automatic logic run_trips(input int unsigned run,
                                     input int unsigned need);
    return run >= need;
  endfunction

endpackage

// File: rtl/blue_alarm_sampler.sv
module blue_alarm_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic win_strobe,
  output logic take,
  output logic is_zero,
  output logic win_end
);
  logic prev_lvl;

  assign take    = bit_valid;
  assign is_zero = bit_valid & ~bit_data;
  assign win_end = bit_valid & prev_lvl & ~win_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_lvl <= 1'b0;
    else if (bit_valid) prev_lvl <= win_strobe;
  end
endmodule

// File: rtl/blue_alarm_tally.sv
module blue_alarm_tally
  import blue_alarm_pkg::*;
#(
  parameter int unsigned ZERO_THRESH = 3,
  localparam int unsigned CNT_W = $clog2(ZERO_THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             is_zero,
  input  logic             win_end,
  output logic [CNT_W-1:0] zero_cnt,
  output logic             win_sparse
);
  int unsigned total;

  always_comb begin
    total      = sat_add(32'(zero_cnt), is_zero ? 32'd1 : 32'd0, ZERO_THRESH);
    win_sparse = is_sparse(total, ZERO_THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zero_cnt <= '0;
    else if (take) begin
      if (win_end)    zero_cnt <= '0;
      else            zero_cnt <= CNT_W'(total);
    end
  end
endmodule

// File: rtl/blue_alarm_ctl.sv
module blue_alarm_ctl
  import blue_alarm_pkg::*;
#(
  parameter int unsigned SET_WINDOWS = 2,
  localparam int unsigned RUN_W = $clog2(SET_WINDOWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             win_sparse,
  output logic [RUN_W-1:0] sparse_run,
  output logic             alarm
);
  generate
    if (SET_WINDOWS <= 1) begin : g_direct
      assign sparse_run = '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       alarm <= 1'b0;
        else if (win_end) alarm <= win_sparse;
      end
    end else begin : g_history
      int unsigned run_next;
      always_comb run_next = sat_add(32'(sparse_run), 32'd1, SET_WINDOWS);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sparse_run <= '0;
          alarm      <= 1'b0;
        end else if (win_end) begin
          if (win_sparse) begin
            sparse_run <= RUN_W'(run_next);
            if (run_trips(run_next, SET_WINDOWS)) alarm <= 1'b1;
          end else begin
            sparse_run <= '0;
            alarm      <= 1'b0;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/blue_alarm_det.sv
module blue_alarm_det #(
  parameter int unsigned ZERO_THRESH = 3,
  parameter int unsigned SET_WINDOWS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic win_strobe,
  output logic alarm_o
);
  localparam int unsigned CNT_W = $clog2(ZERO_THRESH + 1);
  localparam int unsigned RUN_W = $clog2(SET_WINDOWS + 1);

  // Internal events, named so that the checker can reach them.
  logic             take;
  logic             is_zero;
  logic             win_end;
  logic             win_sparse;
  logic [CNT_W-1:0] zero_cnt;
  logic [RUN_W-1:0] sparse_run;

  blue_alarm_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .win_strobe(win_strobe), .take(take), .is_zero(is_zero), .win_end(win_end)
  );

  blue_alarm_tally #(.ZERO_THRESH(ZERO_THRESH)) u_tly (
    .clk(clk), .rst_n(rst_n), .take(take), .is_zero(is_zero),
    .win_end(win_end), .zero_cnt(zero_cnt), .win_sparse(win_sparse)
  );

  blue_alarm_ctl #(.SET_WINDOWS(SET_WINDOWS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_sparse(win_sparse),
    .sparse_run(sparse_run), .alarm(alarm_o)
  );
endmodule

// File: rtl/blue_alarm_det_chk.sv
module blue_alarm_det_chk #(
  parameter int unsigned ZERO_THRESH = 3,
  parameter int unsigned SET_WINDOWS = 2,
  localparam int unsigned CNT_W = $clog2(ZERO_THRESH + 1),
  localparam int unsigned RUN_W = $clog2(SET_WINDOWS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             win_end,
  input logic             win_sparse,
  input logic [CNT_W-1:0] zero_cnt,
  input logic [RUN_W-1:0] sparse_run,
  input logic             alarm
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(zero_cnt) && $stable(alarm)));  // R2
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (zero_cnt == '0));  // R4
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(zero_cnt) <= ZERO_THRESH);  // R5
  AST_SET_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_sparse && (32'(sparse_run) + 1 >= SET_WINDOWS)) |=> alarm);  // R6
  AST_RISE_NEEDS_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(win_end && win_sparse));  // R6
  AST_CLEAR_ON_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_sparse) |=> (!alarm && sparse_run == '0));  // R7
  AST_STABLE_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(alarm));  // R8
endmodule

bind blue_alarm_det blue_alarm_det_chk #(
  .ZERO_THRESH(ZERO_THRESH), .SET_WINDOWS(SET_WINDOWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .win_end(win_end),
  .win_sparse(win_sparse), .zero_cnt(zero_cnt), .sparse_run(sparse_run),
  .alarm(alarm_o)
);

// File: tb/sim_blue_alarm_det.sv
`timescale 1ns/1ps
module sim_blue_alarm_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b1;
  logic win_strobe = 1'b0;
  logic alarm_o;

  int n_checks = 0;
  int n_fails = 0;

  // Reference model, written from the requirements.
  bit m_prev = 0;
  int m_zeros = 0;
  int m_run = 0;
  bit m_alarm = 0;

  always #4 clk = ~clk;

  blue_alarm_det u0 (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
                     .bit_data(bit_data), .win_strobe(win_strobe), .alarm_o(alarm_o));

  task automatic check_alarm(input bit exp, input string req);
    n_checks++;
    if (alarm_o !== exp) begin
      n_fails++;
      $display("FAIL %s: alarm_o=%b expected %b at %0t", req, alarm_o, exp, $time);
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0; bit_data = 1'b1; win_strobe = 1'b0;
    m_prev = 0; m_zeros = 0; m_run = 0; m_alarm = 0;
    repeat (2) @(negedge clk);
    check_alarm(1'b0, req);
    rst_n = 1'b1;
  endtask

  // One clock cycle of stimulus. The model is updated when the bit is qualified.
  task automatic send_bit(input bit v, input bit d, input bit s, input string req);
    @(negedge clk);
    bit_valid = v; bit_data = d; win_strobe = s;
    @(posedge clk);
    if (v) begin
      if (!d) m_zeros++;
      if (m_prev && !s) begin
        if (m_zeros >= 3) begin m_run = 0; m_alarm = 0; end
        else begin m_run++; if (m_run >= 2) m_alarm = 1; end
        m_zeros = 0;
      end
      m_prev = s;
    end
    #2;
    check_alarm(m_alarm, req);
  endtask

  // Sends a window of len qualified bits: nz zeros at the start of the body, a
  // boundary bit that may carry a zero, and junk unqualified cycles after bit 0.
  task automatic window(input int len, input int nz, input bit end_zero,
                        input int junk, input string req);
    for (int i = 0; i < len - 1; i++) begin
      send_bit(1'b1, (i < nz) ? 1'b0 : 1'b1, 1'b1, req);
      if (i == 0)
        for (int j = 0; j < junk; j++) send_bit(1'b0, 1'b0, j[0], req);
    end
    send_bit(1'b1, ~end_zero, 1'b0, req);
  endtask

  task automatic t_reset_and_first_window();
    do_reset("R1");
    // With the strobe held low after reset there is no boundary (R3). These bits
    // also belong to the first window (R9).
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1, 1'b0, "R3");
    window(5, 0, 1'b0, 0, "R9");
    window(6, 2, 1'b0, 0, "R6");
    check_alarm(1'b1, "R6");
  endtask

  task automatic t_boundary_zero();
    window(6, 2, 1'b1, 0, "R4");
    check_alarm(1'b0, "R4");
  endtask

  task automatic t_history_cleared();
    window(6, 0, 1'b0, 0, "R6");
    window(6, 3, 1'b0, 0, "R7");
    window(6, 1, 1'b0, 0, "R7");
    check_alarm(1'b0, "R7");
  endtask

  task automatic t_saturation();
    window(24, 20, 1'b0, 0, "R5");
    window(4, 0, 1'b0, 0, "R5");
    window(4, 2, 1'b0, 0, "R5");
    check_alarm(1'b1, "R5");
  endtask

  task automatic t_hold_high();
    window(5, 1, 1'b0, 0, "R8");
    window(5, 0, 1'b0, 0, "R6");
    window(8, 3, 1'b0, 0, "R7");
    check_alarm(1'b0, "R7");
  endtask

  task automatic t_ignore_unqualified();
    window(6, 2, 1'b0, 6, "R2");
    window(6, 1, 1'b0, 0, "R2");
    check_alarm(1'b1, "R2");
  endtask

  task automatic t_reset_clears();
    do_reset("R1");
    window(4, 2, 1'b0, 0, "R9");
    window(4, 2, 1'b0, 0, "R9");
    check_alarm(1'b1, "R9");
  endtask

  initial begin
    t_reset_and_first_window();
    t_boundary_zero();
    t_history_cleared();
    t_saturation();
    t_hold_high();
    t_ignore_unqualified();
    t_reset_clears();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule